// File: doc/BRIEF.md
# Fixed-Trip Array Summation Engine

This block is a small coprocessor that runs one hard-wired loop: it sums a short array of signed 16-bit values held in memory and hands back a 32-bit total. Software places the array's byte address on the base input and raises start for one cycle. The engine then walks ten consecutive elements at a 2-byte stride. It sign-extends each element to 32 bits and adds it to a running total. When the loop is finished it pulses done and keeps the total on its result output.

The memory side is a plain read port. A request with an address in one cycle returns the element on the read-data input in the following cycle. The port has no back-pressure: there is no ready signal, so the memory must answer every request exactly one cycle after it is made. Start is a control pin, not a stream. It is accepted only when the engine is idle, and pulses that arrive while a run is in progress are dropped.

Top module: `sumacc_top`

## Requirements
- R1: A synchronous reset, active high, drives busy, done and mem_req low and returns the engine to idle, even in the middle of a run.
- R2: Start is accepted in any cycle in which busy is low. The cycle after it is accepted, busy is high and the first request is on the port using the base address captured with start.
- R3: A run issues exactly ten requests, in ten consecutive cycles. Request k (k = 0..9) appears k+1 cycles after the accepting edge, at address base + 2*k. Addresses wrap modulo 2^ADDR_W.
- R4: The element for each request is taken from mem_rdata one cycle after that request, and only in that cycle.
- R5: Each element is treated as two's-complement 16-bit. It is sign-extended to 32 bits before it is added, so that 0x8000 contributes -32768 and 0xFFFF contributes -1.
- R6: The loop exits once the index reaches ten. No request follows the tenth, and busy drops 12 cycles after the accepting edge.
- R7: Done is high for exactly one cycle, 12 cycles after the accepting edge. In that cycle busy is low and result holds the complete sum.
- R8: Result stays unchanged from the done cycle until the next start is accepted. Accepting a start clears the sum to zero.
- R9: A start pulse while busy is high has no effect. The address sequence and the final sum are those of the run already in progress.
- R10: A start given in the done cycle is accepted, so that runs follow each other back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start a run when idle |
| base_addr | input | ADDR_W (16) | Byte address of element 0, captured with start |
| mem_req | output | 1 | Read request this cycle |
| mem_addr | output | ADDR_W (16) | Byte address of the requested element |
| mem_rdata | input | ELEM_W (16) | Element, valid one cycle after its request |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | SUM_W (32) | Accumulated signed sum |

## Verification
Counting from the clock edge that accepts start, the results fall due as follows:
- request k is on the port k+1 cycles later;
- its data is returned one cycle after that;
- the last element is added in cycle 11;
- done and the final sum are visible in cycle 12.

The bench drives start on a falling edge. It then steps one falling edge per cycle and compares the port values against this schedule in the exact cycle each one is due. The memory model returns a poison value whenever no request was made, so an element taken in the wrong cycle shows up in the sum.

// File: rtl/sumacc_pkg.sv
package sumacc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } sum_state_e;

endpackage

// File: rtl/sumacc_ctrl.sv
module sumacc_ctrl
  import sumacc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic last_issue,
  output logic load,
  output logic issue,
  output logic busy,
  output logic done
);

  sum_state_e state_q, state_d;
  logic       done_q;

  assign load  = (state_q == ST_IDLE) && start;
  assign issue = (state_q == ST_ISSUE);
  assign busy  = (state_q != ST_IDLE);
  assign done  = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_ISSUE;
      ST_ISSUE: if (last_issue) state_d = ST_DRAIN;
      ST_DRAIN: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_DRAIN);
    end
  end

endmodule

// File: rtl/sumacc_addr.sv
module sumacc_addr #(
  parameter int ADDR_W       = 16,
  parameter int TRIP         = 10,
  parameter int STRIDE_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              issue,
  input  logic [ADDR_W-1:0] base_in,
  output logic [ADDR_W-1:0] addr,
  output logic              last_issue
);

  localparam int IDX_W = $clog2(TRIP + 1);

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  idx_nxt;
  logic [ADDR_W-1:0] offset;

  assign idx_nxt    = idx_q + IDX_W'(1);
  assign last_issue = issue && !(idx_nxt < IDX_W'(TRIP));

  generate
    if (ADDR_W > IDX_W) begin : g_wide
      assign offset = {{(ADDR_W-IDX_W){1'b0}}, idx_q} << STRIDE_SHIFT;
    end else begin : g_narrow
      assign offset = idx_q[ADDR_W-1:0] << STRIDE_SHIFT;
    end
  endgenerate

  assign addr = base_q + offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      base_q <= base_in;
      idx_q  <= '0;
    end else if (issue) begin
      idx_q  <= idx_nxt;
    end
  end

endmodule

// File: rtl/sumacc_accum.sv
module sumacc_accum #(
  parameter int ELEM_W = 16,
  parameter int SUM_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              issue,
  input  logic [ELEM_W-1:0] rdata,
  output logic [SUM_W-1:0]  acc
);

  logic             pend_q;
  logic [SUM_W-1:0] elem_ext;

  generate
    if (SUM_W > ELEM_W) begin : g_ext
      assign elem_ext = {{(SUM_W-ELEM_W){rdata[ELEM_W-1]}}, rdata};
    end else begin : g_same
      assign elem_ext = rdata[SUM_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      acc    <= '0;
    end else begin
      pend_q <= issue;
      if (clear)       acc <= '0;
      else if (pend_q) acc <= acc + elem_ext;
    end
  end

endmodule

// File: rtl/sumacc_top.sv
module sumacc_top #(
  parameter int ADDR_W       = 16,
  parameter int ELEM_W       = 16,
  parameter int SUM_W        = 32,
  parameter int TRIP         = 10,
  parameter int STRIDE_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [ELEM_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [SUM_W-1:0]  result
);

  logic load;
  logic issue;
  logic last_issue;

  sumacc_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .last_issue (last_issue),
    .load       (load),
    .issue      (issue),
    .busy       (busy),
    .done       (done)
  );

  sumacc_addr #(
    .ADDR_W       (ADDR_W),
    .TRIP         (TRIP),
    .STRIDE_SHIFT (STRIDE_SHIFT)
  ) u_addr (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .issue      (issue),
    .base_in    (base_addr),
    .addr       (mem_addr),
    .last_issue (last_issue)
  );

  sumacc_accum #(
    .ELEM_W (ELEM_W),
    .SUM_W  (SUM_W)
  ) u_acc (
    .clk   (clk),
    .rst   (rst),
    .clear (load),
    .issue (issue),
    .rdata (mem_rdata),
    .acc   (result)
  );

  assign mem_req = issue;

endmodule

// File: rtl/sumacc_chk.sv
module sumacc_chk #(
  parameter int ADDR_W       = 16,
  parameter int SUM_W        = 32,
  parameter int TRIP         = 10,
  parameter int STRIDE_SHIFT = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] base_addr,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              done,
  input logic [SUM_W-1:0]  result
);

  localparam int CNT_W = $clog2(TRIP + 2);

  logic [CNT_W-1:0] req_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) req_cnt <= '0;
    else if (mem_req) req_cnt <= req_cnt + CNT_W'(1);
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && mem_req && mem_addr == $past(base_addr)));

  // R3
  addr_stride_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |->
      (mem_addr == $past(mem_addr) + ADDR_W'(1 << STRIDE_SHIFT)));

  // R6
  trip_limit_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (req_cnt < CNT_W'(TRIP)));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(start)) |-> $stable(result));

endmodule

bind sumacc_top sumacc_chk #(
  .ADDR_W       (ADDR_W),
  .SUM_W        (SUM_W),
  .TRIP         (TRIP),
  .STRIDE_SHIFT (STRIDE_SHIFT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .base_addr (base_addr),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .busy      (busy),
  .done      (done),
  .result    (result)
);

// File: tb/sumacc_top_test.sv
module sumacc_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [15:0] base;
    logic [1:0]  pat;
    logic [31:0] sum;
  } vec_t;

  // pat 0: every element 0x7FFF; pat 1: 0x8000; pat 2: 0xFFFF; pat 3: element = its byte address
  localparam vec_t VECS [0:5] = '{
    '{16'h0040, 2'd0, 32'h0004FFF6},
    '{16'h0200, 2'd1, 32'hFFFB0000},
    '{16'h0011, 2'd2, 32'hFFFFFFF6},
    '{16'h0100, 2'd3, 32'h00000A5A},
    '{16'h1000, 2'd3, 32'h0000A05A},
    '{16'h9000, 2'd3, 32'hFFFBA05A}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] base_addr = '0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = 16'hDEAD;
  logic        busy;
  logic        done;
  logic [31:0] result;
  logic [1:0]  pat_sel = 2'd0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  sumacc_top uut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .base_addr (base_addr),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .done      (done),
    .result    (result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] pat_fn(input logic [1:0] p, input logic [15:0] a);
    case (p)
      2'd0:    return 16'h7FFF;
      2'd1:    return 16'h8000;
      2'd2:    return 16'hFFFF;
      default: return a;
    endcase
  endfunction

  // memory with one-cycle latency; poison when nothing was requested
  always @(posedge clk) begin
    if (mem_req) mem_rdata <= pat_fn(pat_sel, mem_addr);
    else         mem_rdata <= 16'hDEAD;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_sum(input logic [15:0] b, input logic [1:0] p);
    logic [31:0] s = '0;
    for (int i = 0; i < 10; i++) begin
      logic [15:0] e = pat_fn(p, b + 16'(2*i));
      s = s + {{16{e[15]}}, e};
    end
    return s;
  endfunction

  // one run; the accepting edge is the rising edge before cycle 1
  task automatic run_vec(input vec_t v, input bit prestarted, input bit poke_mid,
                         input bit chain, input vec_t nxt);
    logic [31:0] ms = model_sum(v.base, v.pat);
    if (!prestarted) begin
      @(negedge clk);
      pat_sel   = v.pat;
      base_addr = v.base;
      start     = 1'b1;
      @(negedge clk);
      start     = 1'b0;
      base_addr = 16'hBEEF;
    end
    for (int c = 1; c <= 12; c++) begin
      if (c <= 10) begin
        check(mem_req == 1'b1, "R3 request", 32'(mem_req), 32'd1);
        check(mem_addr == v.base + 16'(2*(c-1)), "R3 address", 32'(mem_addr),
              32'(v.base + 16'(2*(c-1))));
        check(busy == 1'b1 && done == 1'b0, "R2 busy", {busy, done}, 32'b10);
      end else if (c == 11) begin
        check(mem_req == 1'b0, "R6 no extra request", 32'(mem_req), 32'd0);
        check(busy == 1'b1 && done == 1'b0, "R6 drain", {busy, done}, 32'b10);
      end else begin
        check(done == 1'b1, "R7 done", 32'(done), 32'd1);
        check(busy == 1'b0, "R6 busy drop", 32'(busy), 32'd0);
        check(result == v.sum, "R5 sum", result, v.sum);
        check(result == ms, "R4 latency sum", result, ms);
      end
      if (poke_mid && c == 5) begin
        start     = 1'b1;  // R9: must be ignored
        base_addr = 16'h3000;
      end
      if (poke_mid && c == 6) start = 1'b0;
      if (chain && c == 12) begin
        pat_sel   = nxt.pat;  // R10: start in the done cycle
        base_addr = nxt.base;
        start     = 1'b1;
      end
      @(negedge clk);
    end
    if (chain) begin
      start     = 1'b0;
      base_addr = 16'hBEEF;
    end else begin
      check(done == 1'b0, "R7 single pulse", 32'(done), 32'd0);
      check(result == v.sum, "R8 hold", result, v.sum);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R1 reset",
          {busy, done, mem_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      run_vec(VECS[v], v == 3, v == 4, v == 2, VECS[(v + 1) % 6]);
    end

    // R8: result held across idle cycles
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(result == VECS[5].sum && !busy, "R8 idle hold", result, VECS[5].sum);
    end

    // R1: reset in the middle of a run
    pat_sel   = 2'd0;
    base_addr = 16'h0400;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R1 mid-run reset",
          {busy, done, mem_req}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && mem_req == 1'b0, "R1 stays idle", {busy, mem_req}, 32'd0);

    // recovery after reset
    run_vec(VECS[3], 1'b0, 1'b0, 1'b0, VECS[0]);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule